// File: doc/BRIEF.md
# Receive Status and Interrupt Logic

This block watches the receive side of a packet radio and turns a few raw events into status levels the processor can read. The events are the fill level of the receive FIFO, a pulse when a whole frame has arrived, a pulse when a start-of-frame delimiter has been found, and a clear-channel indication. From these it produces four status bits:

- a "FIFO not empty" bit;
- a "FIFO needs service" bit, raised either by a fill-level threshold or by a completed frame;
- a delimiter-active level;
- a registered copy of the channel-clear input.

Two sticky interrupt flags latch the rising edges of the service bit and the delimiter level. Software clears a flag by writing 1 to it. A single interrupt request is formed from the flags whose enable bits are set. Any of the four status bits can be routed to each of four debug pins, and each pin has its own inversion control.

All outputs are registered. An input that is present at a rising clock edge shows on the outputs right after that edge. Configuration is written through a small register port:

| Address | Register | Layout |
|---------|----------|--------|
| 0 | Threshold | low CNT_W bits |
| 1 | Pin map | 2 bits per pin |
| 2 | Pin polarity | 1 bit per pin |
| 3 | Interrupt enable | bit 0, bit 1 |
| 4 | Flag clear | write 1 to clear |

A register write takes effect on the edge that follows the write edge.

Top module: `rx_status_irq`

## Requirements
- R1: `st_fifo` is 1 after every edge at which `fifo_count` was non-zero, and 0 otherwise.
- R2: `st_fifop` is 1 after an edge at which `fifo_count` was strictly greater than the stored threshold. A count equal to the threshold does not count as above it.
- R3: A `frame_done` pulse sets a frame-held condition that keeps `st_fifop` at 1 whatever the count. The condition is dropped at the first edge where `fifo_count` is 0 and no new `frame_done` is present.
- R4: `st_sfd` rises after an edge with `sfd_det`, falls after an edge with `frame_done`, and otherwise holds. If both pulses arrive at the same edge, `sfd_det` wins.
- R5: `st_cca` equals the `cca_in` value that was present at the previous edge.
- R6: Flag bit 0 sets when `st_fifop` goes from 0 to 1. Flag bit 1 sets when `st_sfd` goes from 0 to 1. Both change at the same edge as the status bit.
- R7: Writing to address 4 clears every flag whose data bit is 1. Data bits that are 0 leave their flags unchanged. If a set and a clear hit the same flag at the same edge, the set wins.
- R8: `irq` is the OR of the updated flags ANDed with the enable register (address 3, bits 1:0). It is updated at the same edge as the flags.
- R9: Bits [2i+1:2i] of address 1 choose the source for `dbg_pin[i]`: 0 = delimiter level, 1 = FIFO not empty, 2 = FIFO service, 3 = channel clear. Each pin changes at the same edge as the status bit it shows.
- R10: Bit i of address 2 inverts `dbg_pin[i]`.
- R11: After reset the following hold:
  - all status bits, flags, `irq` and enables are 0;
  - the threshold is RST_THR;
  - pin i shows source i with no inversion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_count | input | CNT_W | Receive FIFO fill level in bytes |
| frame_done | input | 1 | One-cycle pulse: complete frame received |
| sfd_det | input | 1 | One-cycle pulse: start-of-frame delimiter detected |
| cca_in | input | 1 | Channel-clear indication |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| st_fifo | output | 1 | FIFO not empty |
| st_fifop | output | 1 | FIFO needs service |
| st_sfd | output | 1 | Delimiter-active level |
| st_cca | output | 1 | Registered channel-clear |
| irq_flags | output | 2 | Sticky flags (bit 0 service, bit 1 delimiter) |
| irq | output | 1 | Combined interrupt request |
| dbg_pin | output | DBG_N | Debug outputs |

## Verification
The bench targets the following corner cases, each with the fault it would expose:

- A count exactly equal to the threshold and one above it. A design using `>=` would raise the service bit one byte too early.
- A frame completing while the count is below the threshold, then draining to empty. A design that dropped the frame-held term would never raise the service bit. A design that never cleared the term would leave it stuck high.
- Delimiter and frame-complete pulses at the same edge. A wrong priority would leave the delimiter level low.
- A flag clear written at the same edge as a new rising edge. If the clear won, an event would be lost.
- All pins mapped to one source with mixed inversion, plus long random traffic. These expose swapped map fields and polarity bits.

// File: rtl/rx_stat_pkg.sv
package rx_stat_pkg;
  localparam int ADR_THR = 0;
  localparam int ADR_MAP = 1;
  localparam int ADR_POL = 2;
  localparam int ADR_IEN = 3;
  localparam int ADR_CLR = 4;
  localparam int NUM_FLG = 2;
  localparam int FLG_FIFOP = 0;
  localparam int FLG_SFD = 1;
  localparam int SEL_W = 2;
  typedef enum logic [SEL_W-1:0] {
    SRC_SFD   = 2'd0,
    SRC_FIFO  = 2'd1,
    SRC_FIFOP = 2'd2,
    SRC_CCA   = 2'd3
  } dbg_src_e;
endpackage

// File: rtl/rx_cfg_regs.sv
module rx_cfg_regs #(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int RST_THR = 64,
  parameter int DBG_N   = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          we,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wdata,
  output logic [CNT_W-1:0]              thr,
  output logic [rx_stat_pkg::SEL_W*DBG_N-1:0] pin_map,
  output logic [DBG_N-1:0]              pin_pol,
  output logic [rx_stat_pkg::NUM_FLG-1:0] ien,
  output logic [rx_stat_pkg::NUM_FLG-1:0] clr
);
  import rx_stat_pkg::*;
  localparam int MAP_W = SEL_W * DBG_N;

  function automatic logic [MAP_W-1:0] ident_map();
    logic [MAP_W-1:0] m;
    m = '0;
    for (int i = 0; i < DBG_N; i++) m[SEL_W*i +: SEL_W] = SEL_W'(i);
    return m;
  endfunction

  localparam logic [MAP_W-1:0] MAP_RST = ident_map();

  logic hit_thr, hit_map, hit_pol, hit_ien, hit_clr;
  assign hit_thr = we && (addr == ADDR_W'(ADR_THR));
  assign hit_map = we && (addr == ADDR_W'(ADR_MAP));
  assign hit_pol = we && (addr == ADDR_W'(ADR_POL));
  assign hit_ien = we && (addr == ADDR_W'(ADR_IEN));
  assign hit_clr = we && (addr == ADDR_W'(ADR_CLR));

  logic unused_wdata;
  assign unused_wdata = ^wdata;

  assign clr = hit_clr ? wdata[NUM_FLG-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      thr     <= CNT_W'(RST_THR);
      pin_map <= MAP_RST;
      pin_pol <= '0;
      ien     <= '0;
    end else begin
      if (hit_thr) thr     <= wdata[CNT_W-1:0];
      if (hit_map) pin_map <= wdata[MAP_W-1:0];
      if (hit_pol) pin_pol <= wdata[DBG_N-1:0];
      if (hit_ien) ien     <= wdata[NUM_FLG-1:0];
    end
  end

  // R11: threshold returns to its reset value after reset
  a_r11_thr_reset: assert property (@(posedge clk) $fell(rst) |-> thr == CNT_W'(RST_THR));
endmodule

// File: rtl/rx_status_track.sv
module rx_status_track #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             frame_done,
  input  logic             sfd_det,
  input  logic             cca_in,
  input  logic [CNT_W-1:0] thr,
  output logic             st_fifo,
  output logic             st_fifop,
  output logic             st_sfd,
  output logic             st_cca,
  output logic             nx_fifo,
  output logic             nx_fifop,
  output logic             nx_sfd,
  output logic             rise_fifop,
  output logic             rise_sfd
);
  logic frm_held, nx_frm;

  always_comb begin
    nx_fifo  = (fifo_count != '0);
    nx_frm   = frame_done | (frm_held & nx_fifo);
    nx_fifop = (fifo_count > thr) | nx_frm;
    if (sfd_det)         nx_sfd = 1'b1;
    else if (frame_done) nx_sfd = 1'b0;
    else                 nx_sfd = st_sfd;
    rise_fifop = nx_fifop & ~st_fifop;
    rise_sfd   = nx_sfd & ~st_sfd;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_held <= 1'b0;
      st_fifo  <= 1'b0;
      st_fifop <= 1'b0;
      st_sfd   <= 1'b0;
      st_cca   <= 1'b0;
    end else begin
      frm_held <= nx_frm;
      st_fifo  <= nx_fifo;
      st_fifop <= nx_fifop;
      st_sfd   <= nx_sfd;
      st_cca   <= cca_in;
    end
  end

  // R1: non-empty FIFO shows on the status bit
  a_r1_fifo_set: assert property (@(posedge clk) disable iff (rst)
    (fifo_count != '0) |=> st_fifo);
  // R2: count above threshold raises service bit
  a_r2_thr: assert property (@(posedge clk) disable iff (rst)
    (fifo_count > thr) |=> st_fifop);
  // R3: completed frame raises service bit
  a_r3_frame: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> st_fifop);
  // R4: delimiter pulse raises the level
  a_r4_sfd: assert property (@(posedge clk) disable iff (rst)
    sfd_det |=> st_sfd);
  // R5: channel clear copied one cycle later
  a_r5_cca: assert property (@(posedge clk) disable iff (rst)
    cca_in |=> st_cca);
endmodule

// File: rtl/rx_irq_flags.sv
module rx_irq_flags #(
  parameter int NFLG = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NFLG-1:0] set,
  input  logic [NFLG-1:0] clr,
  input  logic [NFLG-1:0] ien,
  output logic [NFLG-1:0] flags,
  output logic            irq
);
  logic [NFLG-1:0] nx_flags;

  assign nx_flags = (flags & ~clr) | set;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      irq   <= 1'b0;
    end else begin
      flags <= nx_flags;
      irq   <= |(nx_flags & ien);
    end
  end

  for (genvar g = 0; g < NFLG; g++) begin : g_chk
    // R7: a flag holds until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags[g] && !clr[g]) |=> flags[g]);
    // R6: a set event always lands in the flag
    a_r6_set: assert property (@(posedge clk) disable iff (rst)
      set[g] |=> flags[g]);
  end

  // R8: request only with an enabled flag
  a_r8_irq: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|(flags & $past(ien))));
endmodule

// File: rtl/rx_dbg_mux.sv
module rx_dbg_mux #(
  parameter int DBG_N = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic [3:0]                          src,
  input  logic [rx_stat_pkg::SEL_W*DBG_N-1:0] pin_map,
  input  logic [DBG_N-1:0]                    pin_pol,
  output logic [DBG_N-1:0]                    dbg_pin
);
  import rx_stat_pkg::*;

  for (genvar p = 0; p < DBG_N; p++) begin : g_pin
    logic [SEL_W-1:0] sel;
    assign sel = pin_map[SEL_W*p +: SEL_W];
    always_ff @(posedge clk) begin
      if (rst) dbg_pin[p] <= 1'b0;
      else     dbg_pin[p] <= src[sel] ^ pin_pol[p];
    end
  end
endmodule

// File: rtl/rx_status_irq.sv
module rx_status_irq #(
  parameter int CNT_W   = 8,
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 3,
  parameter int RST_THR = 64,
  parameter int DBG_N   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CNT_W-1:0]  fifo_count,
  input  logic              frame_done,
  input  logic              sfd_det,
  input  logic              cca_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic              st_fifo,
  output logic              st_fifop,
  output logic              st_sfd,
  output logic              st_cca,
  output logic [1:0]        irq_flags,
  output logic              irq,
  output logic [DBG_N-1:0]  dbg_pin
);
  import rx_stat_pkg::*;
  localparam int MAP_W = SEL_W * DBG_N;

  logic [CNT_W-1:0]   thr;
  logic [MAP_W-1:0]   pin_map;
  logic [DBG_N-1:0]   pin_pol;
  logic [NUM_FLG-1:0] ien, clr, set;
  logic nx_fifo, nx_fifop, nx_sfd, rise_fifop, rise_sfd;
  logic [3:0] src;

  rx_cfg_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
                .RST_THR(RST_THR), .DBG_N(DBG_N)) u_cfg (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .thr(thr), .pin_map(pin_map), .pin_pol(pin_pol), .ien(ien), .clr(clr));

  rx_status_track #(.CNT_W(CNT_W)) u_trk (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .frame_done(frame_done),
    .sfd_det(sfd_det), .cca_in(cca_in), .thr(thr),
    .st_fifo(st_fifo), .st_fifop(st_fifop), .st_sfd(st_sfd), .st_cca(st_cca),
    .nx_fifo(nx_fifo), .nx_fifop(nx_fifop), .nx_sfd(nx_sfd),
    .rise_fifop(rise_fifop), .rise_sfd(rise_sfd));

  always_comb begin
    set = '0;
    set[FLG_FIFOP] = rise_fifop;
    set[FLG_SFD]   = rise_sfd;
    src = '0;
    src[SRC_SFD]   = nx_sfd;
    src[SRC_FIFO]  = nx_fifo;
    src[SRC_FIFOP] = nx_fifop;
    src[SRC_CCA]   = cca_in;
  end

  rx_irq_flags #(.NFLG(NUM_FLG)) u_flg (
    .clk(clk), .rst(rst), .set(set), .clr(clr), .ien(ien),
    .flags(irq_flags), .irq(irq));

  rx_dbg_mux #(.DBG_N(DBG_N)) u_dbg (
    .clk(clk), .rst(rst), .src(src), .pin_map(pin_map), .pin_pol(pin_pol),
    .dbg_pin(dbg_pin));
endmodule

// File: tb/rx_status_irq_bench.sv
module rx_status_irq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int RST_THR = 64;

  logic clk = 0, rst = 1;
  logic [CNT_W-1:0] fifo_count = '0;
  logic frame_done = 0, sfd_det = 0, cca_in = 0, reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic st_fifo, st_fifop, st_sfd, st_cca, irq;
  logic [1:0] irq_flags;
  logic [3:0] dbg_pin;

  rx_status_irq u_rx_status_irq (
    .clk(clk), .rst(rst), .fifo_count(fifo_count), .frame_done(frame_done),
    .sfd_det(sfd_det), .cca_in(cca_in), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .st_fifo(st_fifo), .st_fifop(st_fifop),
    .st_sfd(st_sfd), .st_cca(st_cca), .irq_flags(irq_flags), .irq(irq),
    .dbg_pin(dbg_pin));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // spec model state
  logic [CNT_W-1:0] m_thr;
  logic [7:0] m_map;
  logic [3:0] m_pol, m_dbg;
  logic [1:0] m_ien, m_flags;
  logic m_fifo, m_fifop, m_frm, m_sfd, m_cca, m_irq;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    logic f_n, frm_n, p_n, s_n;
    logic [1:0] set_v, clr_v, fl_n;
    logic [3:0] src;
    if (rst) begin
      m_thr = CNT_W'(RST_THR); m_map = 8'b11_10_01_00; m_pol = '0; m_ien = '0;
      m_flags = '0; m_fifo = 0; m_fifop = 0; m_frm = 0; m_sfd = 0; m_cca = 0;
      m_irq = 0; m_dbg = '0;
      return;
    end
    f_n   = (fifo_count != 0);
    frm_n = frame_done | (m_frm & f_n);
    p_n   = (fifo_count > m_thr) | frm_n;
    s_n   = sfd_det ? 1'b1 : (frame_done ? 1'b0 : m_sfd);
    set_v = {s_n & ~m_sfd, p_n & ~m_fifop};
    clr_v = (reg_we && reg_addr == 3'd4) ? reg_wdata[1:0] : 2'b00;
    fl_n  = (m_flags & ~clr_v) | set_v;
    m_irq = |(fl_n & m_ien);
    src   = {cca_in, p_n, f_n, s_n};
    for (int i = 0; i < 4; i++) m_dbg[i] = src[m_map[2*i +: 2]] ^ m_pol[i];
    m_flags = fl_n; m_fifo = f_n; m_frm = frm_n; m_fifop = p_n; m_sfd = s_n;
    m_cca = cca_in;
    if (reg_we) begin
      case (reg_addr)
        3'd0: m_thr = reg_wdata;
        3'd1: m_map = reg_wdata;
        3'd2: m_pol = reg_wdata[3:0];
        3'd3: m_ien = reg_wdata[1:0];
        default: ;
      endcase
    end
  endtask

  task automatic compare_all(input string ctx);
    chk({ctx, " R1 st_fifo"}, st_fifo, m_fifo);
    chk({ctx, " R2 R3 st_fifop"}, st_fifop, m_fifop);
    chk({ctx, " R4 st_sfd"}, st_sfd, m_sfd);
    chk({ctx, " R5 st_cca"}, st_cca, m_cca);
    chk({ctx, " R6 R7 irq_flags"}, irq_flags, m_flags);
    chk({ctx, " R8 irq"}, irq, m_irq);
    chk({ctx, " R9 R10 dbg_pin"}, dbg_pin, m_dbg);
  endtask

  task automatic tick(input string ctx);
    @(posedge clk);
    model_step();
    #1;
    compare_all(ctx);
    @(negedge clk);
    frame_done = 0; sfd_det = 0; reg_we = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input string ctx);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    tick(ctx);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    rst = 1;
    tick("R11 reset");
    tick("R11 reset");
    rst = 0;
    tick("R11 idle");
    wr(3'd3, 8'h03, "R8 enable");
    // R2 threshold boundary: equal does not fire, one above does
    wr(3'd0, 8'd5, "R2 thr write");
    fifo_count = 8'd5; tick("R2 count==thr");
    fifo_count = 8'd6; tick("R2 count>thr");
    wr(3'd4, 8'h01, "R7 clear fifop flag");
    fifo_count = 8'd0; tick("R1 empty");
    // R3 frame below threshold, held, cleared on empty
    fifo_count = 8'd2; frame_done = 1; tick("R3 frame");
    fifo_count = 8'd1; tick("R3 held");
    fifo_count = 8'd0; tick("R3 drained");
    // R4 priority of detect over done
    sfd_det = 1; frame_done = 1; tick("R4 both");
    frame_done = 1; tick("R4 fall");
    // R7 set wins over clear
    wr(3'd4, 8'h03, "R7 clear all");
    fifo_count = 8'd9; reg_we = 1; reg_addr = 3'd4; reg_wdata = 8'h01;
    tick("R7 set beats clear");
    wr(3'd4, 8'h00, "R7 zero write no effect");
    // R9 R10 all pins on CCA with mixed polarity
    wr(3'd1, 8'hFF, "R9 map cca");
    wr(3'd2, 8'h05, "R10 pol");
    cca_in = 1; tick("R9 cca high");
    cca_in = 0; tick("R10 cca low");
    wr(3'd1, 8'b00_01_10_11, "R9 reversed map");
    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = $urandom_range(0, 99);
      if (r < 20) fifo_count = 8'd0;
      else fifo_count = CNT_W'($urandom_range(0, 255));
      frame_done = ($urandom_range(0, 9) == 0);
      sfd_det    = ($urandom_range(0, 9) == 0);
      cca_in     = $urandom_range(0, 1);
      if ($urandom_range(0, 7) == 0) begin
        reg_we = 1; reg_addr = 3'($urandom_range(0, 5));
        reg_wdata = 8'($urandom_range(0, 255));
      end
      tick("random");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule